// File: doc/BRIEF.md
# Recirculating Vector Shift Register

This block stores one vector of `LEN` elements, each `WIDTH` bits wide, in a closed ring of registers. Every clock, one element leaves the ring on the serial output and one element enters at the head of the ring. When the load strobe is high, the entering element is the word on the serial input. When the load strobe is low, the element that is leaving is fed back into the head. The stored vector therefore comes out again, unchanged and in the same order, once every `LEN` cycles.

A producer writes a vector by holding the load strobe high for `LEN` consecutive cycles, with element k presented in cycle k. Element k then appears on the output in cycle k+`LEN`. After the strobe drops, the vector keeps circulating for as long as the strobe stays low. A consumer such as a multiply-accumulate stage can read it as often as it needs, one element per clock. A load that lasts fewer than `LEN` cycles replaces only the ring positions that pass the head while the strobe is high.

Top module: `recirc_vector`

## Requirements
- R1: When `load_i` is high in cycle T, the word on `data_i` in cycle T appears on `data_o` in cycle T+`LEN`.
- R2: When `load_i` is low in cycle T, `data_o` in cycle T+`LEN` equals `data_o` in cycle T. The stored vector recirculates without change.
- R3: In the first `LEN` cycles after reset is released, `data_o` is zero, whatever `load_i` and `data_i` do.
- R4: Elements written in consecutive cycles 0..`LEN`-1 leave in the same order in cycles `LEN`..2·`LEN`-1. The latency is exactly `LEN` cycles.
- R5: `rst_i` is synchronous and active high. It clears every stored element to zero, including when it is applied in the middle of operation.
- R6: While `load_i` stays low, `data_i` is ignored. The same vector is re-emitted on every pass, for any number of passes.
- R7: A load lasting fewer than `LEN` cycles overwrites only the positions written during it. All other positions keep their previous values.
- R8: All `WIDTH` bits of an element are carried intact, including the all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | High: take `data_i` into the ring; low: recirculate the leaving element |
| data_i | input | WIDTH | Element to be written |
| data_o | output | WIDTH | Element leaving the ring this cycle |

## Verification
The bench builds two instances. The first uses `LEN`=5 and `WIDTH`=16. An odd ring length makes stale or misordered positions show up across passes, and the 16-bit width makes an all-ones element reach every bit. The second uses `LEN`=1 and `WIDTH`=8. It is the degenerate ring in which the head register is also the output register, so a load takes effect after a single cycle and a recirculation is a plain hold.

// File: rtl/recirc_pkg.sv
package recirc_pkg;

    localparam int unsigned DEF_WIDTH = 32;
    localparam int unsigned DEF_LEN   = 4;

    // Where the head of the ring takes its next element from.
    typedef enum logic {
        FEED_LOOP = 1'b0,
        FEED_NEW  = 1'b1
    } feed_src_e;

    function automatic feed_src_e feed_from_load(input logic load);
        return load ? FEED_NEW : FEED_LOOP;
    endfunction

endpackage

// File: rtl/recirc_cell.sv
module recirc_cell #(
    parameter int unsigned WIDTH = recirc_pkg::DEF_WIDTH
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/recirc_feed_sel.sv
module recirc_feed_sel
    import recirc_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             load_i,
    input  logic [WIDTH-1:0] fresh_i,
    input  logic [WIDTH-1:0] loop_i,
    output logic [WIDTH-1:0] head_o
);

    feed_src_e src;

    always_comb begin
        src = feed_from_load(load_i);
        unique case (src)
            FEED_NEW:  head_o = fresh_i;
            FEED_LOOP: head_o = loop_i;
            default:   head_o = loop_i;
        endcase
    end

endmodule

// File: rtl/recirc_vector.sv
module recirc_vector
    import recirc_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned LEN   = DEF_LEN
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o
);

    localparam int unsigned TAIL = LEN - 1;

    logic [LEN-1:0][WIDTH-1:0] stage_q;
    logic [WIDTH-1:0]          head_d;

    // Head selection: new word or the element leaving the tail.
    recirc_feed_sel #(.WIDTH(WIDTH)) u_feed (
        .load_i  (load_i),
        .fresh_i (data_i),
        .loop_i  (stage_q[TAIL]),
        .head_o  (head_d)
    );

    // Ring of registers: position 0 is the head, TAIL drives the output.
    for (genvar i = 0; i < LEN; i++) begin : g_ring
        if (i == 0) begin : g_head
            recirc_cell #(.WIDTH(WIDTH)) u_cell (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .d_i   (head_d),
                .q_o   (stage_q[0])
            );
        end else begin : g_body
            recirc_cell #(.WIDTH(WIDTH)) u_cell (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .d_i   (stage_q[i-1]),
                .q_o   (stage_q[i])
            );
        end
    end

    assign data_o = stage_q[TAIL];

endmodule

// File: rtl/recirc_vector_chk.sv
module recirc_vector_chk #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned LEN   = 4
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic                      load_i,
    input logic [WIDTH-1:0]          data_i,
    input logic [WIDTH-1:0]          data_o,
    input logic [LEN-1:0][WIDTH-1:0] ring_i
);

    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] warm_q;
    logic          armed_q;

    // Cycles since reset release, saturating at LEN.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            warm_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (warm_q != CW'(LEN)) warm_q <= warm_q + 1'b1;
        end
    end

    // R3
    assert_warmup_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm_q < CW'(LEN)) |-> (data_o == '0));

    // R1
    assert_head_load_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(load_i)) |-> (ring_i[0] == $past(data_i)));

    // R2
    assert_head_loop_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && !$past(load_i)) |-> (ring_i[0] == $past(data_o)));

    // R4: each position advances by exactly one per clock.
    for (genvar i = 1; i < LEN; i++) begin : g_adv
        assert_advance_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            armed_q |-> (ring_i[i] == $past(ring_i[i-1])));
    end

endmodule

bind recirc_vector recirc_vector_chk #(.WIDTH(WIDTH), .LEN(LEN)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load_i),
    .data_i (data_i),
    .data_o (data_o),
    .ring_i (stage_q)
);

// File: tb/tb_recirc_vector.sv
`timescale 1ns/1ps
module tb_recirc_vector;

    localparam int unsigned W5 = 16;
    localparam int unsigned L5 = 5;
    localparam int unsigned W1 = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          load;
    logic [W5-1:0] din;
    logic [W5-1:0] dout;
    logic [W1-1:0] dout1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int mq5[$];
    int mq1[$];

    always #10 clk = ~clk;

    recirc_vector #(.WIDTH(W5), .LEN(L5)) dut (
        .clk_i(clk), .rst_i(rst), .load_i(load), .data_i(din), .data_o(dout));

    recirc_vector #(.WIDTH(W1), .LEN(1)) dut_one (
        .clk_i(clk), .rst_i(rst), .load_i(load), .data_i(din[W1-1:0]), .data_o(dout1));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        mq5.delete(); mq1.delete();
        for (int i = 0; i < L5; i++) mq5.push_back(0);
        mq1.push_back(0);
    endtask

    // Called just after a falling edge: compare, drive, take one rising edge.
    task automatic cyc(input string tag, input bit en, input int d);
        int h5, h1;
        check({tag, " len5"}, int'(dout), mq5[0]);
        check({tag, " len1"}, int'(dout1), mq1[0]);
        load = en;
        din  = W5'(d);
        @(posedge clk);
        h5 = mq5.pop_front();
        h1 = mq1.pop_front();
        mq5.push_back(en ? (d & 16'hFFFF) : h5);
        mq1.push_back(en ? (d & 8'hFF) : h1);
        @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1; load = 1'b0; din = '0;
        repeat (n) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load = 1'b0; din = '0;
        @(negedge clk);
        do_reset(3);
        // R5 reset state
        check("R5 reset state", int'(dout), 0);
        check("R5 reset state len1", int'(dout1), 0);

        // R3: first LEN cycles output zero while a vector is written.
        for (int k = 0; k < L5; k++) begin
            if (k >= 1) check("R3 len1 first cycle only", int'(dout1), k);
            check("R3 warmup zero", int'(dout), 0);
            cyc("R3", 1'b1, k + 1);
        end

        // R4: order preserved, latency exactly LEN.
        for (int k = 0; k < L5; k++) begin
            check("R4 order", int'(dout), k + 1);
            cyc("R4", 1'b0, 16'hDEAD);
        end

        // R2 / R6: load low, data_i toggling, vector re-emitted each pass.
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < L5; k++) begin
                check("R6 ignored input", int'(dout), k + 1);
                cyc("R2", 1'b0, (p * 7 + k) * 16'h1111);
            end
        end

        // R7: partial overwrite of positions 0 and 1 only.
        cyc("R7", 1'b1, 16'h00A0);
        cyc("R7", 1'b1, 16'h00A1);
        for (int k = 2; k < L5; k++) cyc("R7", 1'b0, 16'hFFFF);
        check("R7 pos0", int'(dout), 16'h00A0);
        cyc("R7", 1'b0, 0);
        check("R7 pos1", int'(dout), 16'h00A1);
        cyc("R7", 1'b0, 0);
        check("R7 pos2 kept", int'(dout), 3);
        for (int k = 0; k < 2 * L5; k++) cyc("R7", 1'b0, 16'h5555);

        // R1 / R8: continuous streaming, including all-ones.
        for (int k = 0; k < 4 * L5; k++) begin
            cyc("R1", 1'b1, (k % 3 == 0) ? 16'hFFFF : (k * 16'h0931 + 16'h0101));
        end
        for (int k = 0; k < 2 * L5; k++) cyc("R8", 1'b0, 0);
        cyc("R8", 1'b1, 16'hFFFF);
        for (int k = 1; k < L5; k++) cyc("R8", 1'b0, 0);
        check("R8 all ones", int'(dout), 16'hFFFF);
        check("R8 all ones len1", int'(dout1), 16'hFF);

        // R5: reset in the middle of operation clears everything.
        do_reset(2);
        for (int k = 0; k < 2 * L5; k++) begin
            check("R5 cleared", int'(dout), 0);
            cyc("R5", 1'b0, 16'h7777);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule